// File: doc/BRIEF.md
# Timer Prescaler Front End with Debug Freeze

This block is the counting front end of a general-purpose timer. It holds a 9-bit free-running prescaler, a two-stage synchronizer for each timer input pin, and an 8-bit pulse accumulator. The accumulator counts rising edges seen on one selected synchronized pin.

For debugging there are two control bits. The freeze bit halts the prescaler, the accumulator and the synchronizers. While frozen, pin reads keep returning the values that were synchronized when the freeze began. The single-step bit, written while frozen, moves all frozen logic forward by one tick and then clears itself.

A small register interface gives access to the block. It has one write port and one combinational read port, each with a 2-bit address. The write port holds the control bits, and writing the accumulator address clears its overflow flag. The read port returns the control state, the synchronized pins, the prescaler and the accumulator.

Top module: `tpf_top`

## Requirements
- R1: While not frozen, the prescaler (read at address 2) increments by one on every clock and wraps from 511 to 0. While frozen with no step pending, neither the prescaler nor the accumulator changes.
- R2: While frozen with no step pending, changes on `pin_in` have no effect. The pin read (address 1) and the accumulator stay unchanged.
- R3: The pin read returns the pins after two register stages, so a pin change shows up two clocks later. Once freeze is set, the read holds the synchronized value present at that moment.
- R4: A step write while frozen causes exactly one tick, on the clock after the write. In that tick the prescaler increments by one and every synchronizer stage shifts by one. A pending edge therefore moves forward one stage per step, and it is counted on the step after it reaches the second stage.
- R5: The pending-step bit, read at address 0 bit 1, clears itself after its tick. The step write may be repeated, and each write gives exactly one more tick.
- R6: The accumulator (read at address 3, bits 7:0) counts rising edges of synchronized pin `sel`. `sel` is control bits 3:2. The accumulator wraps from 255 to 0 and sets an overflow flag at read bit 8. Any write to address 3 clears that flag, unless a wrap happens in the same cycle.
- R7: A step write while the freeze bit is clear has no effect. The pending-step bit reads 0 on the following cycle.
- R8: Clearing the freeze bit resumes counting from the frozen value. The first increment comes one clock after the write, with no value lost or skipped.
- R9: Reset clears all state to zero. Control register at address 0: bit 0 is freeze, bit 1 is step, bits 3:2 are `sel`, and every write loads all of these fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPIN | Asynchronous timer input pins |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address: 0 control, 3 clear overflow |
| wr_data | input | WW | Write data: freeze, step, sel |
| rd_addr | input | 2 | Read address: 0 control, 1 pins, 2 prescaler, 3 accumulator |
| rd_data | output | DW | Combinational read data |

## Verification
The bench targets the freeze boundary. It checks that a design stops counting exactly one clock after the freeze write, since a design that froze a cycle late or early would show a prescaler off by one. It single-steps a rising edge through the synchronizers and expects the count only on the third step; a design that counted too early or skipped the edge stage would break this. It repeats step writes and issues step writes while running, so a step bit that stuck, or that was honoured outside freeze, would show up in the control read. It also drives more than 256 edges across the accumulator wrap, including pulses on unselected pins. There it checks the overflow flag, the flag clear, and that a wrong pin selection or a lost wrap would change the count.

// File: rtl/tpf_pkg.sv
package tpf_pkg;

  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_PINS  = 2'd1,
    ADDR_PRESC = 2'd2,
    ADDR_ACC   = 2'd3
  } tpf_addr_e;

  // modular increment of a w-bit quantity
  function automatic logic [31:0] wrap_inc(input logic [31:0] v, input int unsigned w);
    logic [31:0] mask;
    mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return (v + 32'd1) & mask;
  endfunction

  // true when a w-bit value is at its maximum
  function automatic logic at_max(input logic [31:0] v, input int unsigned w);
    logic [31:0] mask;
    mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return (v & mask) == mask;
  endfunction

endpackage

// File: rtl/tpf_ctrl.sv
module tpf_ctrl #(
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ctrl,
  input  logic            wr_freeze,
  input  logic            wr_step,
  input  logic [SELW-1:0] wr_sel,
  output logic            freeze,
  output logic            step_pend,
  output logic            step_set,
  output logic            advance,
  output logic [SELW-1:0] sel
);

  // a step request is honoured only when already frozen
  assign step_set = wr_ctrl && wr_step && freeze;
  assign advance  = !freeze || step_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freeze    <= 1'b0;
      step_pend <= 1'b0;
      sel       <= '0;
    end else begin
      if (step_set)     step_pend <= 1'b1;
      else if (advance) step_pend <= 1'b0;
      if (wr_ctrl) begin
        freeze <= wr_freeze;
        sel    <= wr_sel;
      end
    end
  end

endmodule

// File: rtl/tpf_sync.sv
module tpf_sync #(
  parameter int NPIN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pins_q,
  output logic [NPIN-1:0] rise
);

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic st1, st2, st3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1 <= 1'b0;
        st2 <= 1'b0;
        st3 <= 1'b0;
      end else if (advance) begin
        st1 <= pin_in[i];
        st2 <= st1;
        st3 <= st2;
      end
    end
    assign pins_q[i] = st2;
    assign rise[i]   = st2 & ~st3;
  end

endmodule

// File: rtl/tpf_count.sv
module tpf_count
  import tpf_pkg::*;
#(
  parameter int PW = 9,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic          rise_sel,
  input  logic          ovf_clr,
  output logic [PW-1:0] presc,
  output logic [AW-1:0] acc,
  output logic          ovf,
  output logic          acc_inc,
  output logic          acc_wrap
);

  assign acc_inc  = advance && rise_sel;
  assign acc_wrap = acc_inc && at_max(32'(acc), AW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc <= '0;
      acc   <= '0;
      ovf   <= 1'b0;
    end else begin
      if (advance) presc <= PW'(wrap_inc(32'(presc), PW));
      if (acc_inc) acc   <= AW'(wrap_inc(32'(acc), AW));
      if (acc_wrap)     ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end

endmodule

// File: rtl/tpf_top.sv
module tpf_top
  import tpf_pkg::*;
#(
  parameter int NPIN = 4,
  parameter int PW   = 9,
  parameter int AW   = 8,
  parameter int DW   = 16,
  parameter int WW   = 2 + $clog2(NPIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_in,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [WW-1:0]   wr_data,
  input  logic [1:0]      rd_addr,
  output logic [DW-1:0]   rd_data
);

  localparam int SELW = WW - 2;

  logic            freeze, step_pend, step_set, advance;
  logic [SELW-1:0] sel;
  logic [NPIN-1:0] pins_q, rise;
  logic [PW-1:0]   presc;
  logic [AW-1:0]   acc;
  logic            ovf, acc_inc, acc_wrap;
  logic            wr_ctrl, ovf_clr, rise_sel;

  assign wr_ctrl  = wr_en && (wr_addr == ADDR_CTRL);
  assign ovf_clr  = wr_en && (wr_addr == ADDR_ACC);
  assign rise_sel = rise[sel];

  tpf_ctrl #(.SELW(SELW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctrl   (wr_ctrl),
    .wr_freeze (wr_data[0]),
    .wr_step   (wr_data[1]),
    .wr_sel    (wr_data[WW-1:2]),
    .freeze    (freeze),
    .step_pend (step_pend),
    .step_set  (step_set),
    .advance   (advance),
    .sel       (sel)
  );

  tpf_sync #(.NPIN(NPIN)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (advance),
    .pin_in  (pin_in),
    .pins_q  (pins_q),
    .rise    (rise)
  );

  tpf_count #(.PW(PW), .AW(AW)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (advance),
    .rise_sel (rise_sel),
    .ovf_clr  (ovf_clr),
    .presc    (presc),
    .acc      (acc),
    .ovf      (ovf),
    .acc_inc  (acc_inc),
    .acc_wrap (acc_wrap)
  );

  always_comb begin
    unique case (rd_addr)
      ADDR_CTRL:  rd_data = DW'({sel, step_pend, freeze});
      ADDR_PINS:  rd_data = DW'(pins_q);
      ADDR_PRESC: rd_data = DW'(presc);
      default:    rd_data = DW'({ovf, acc});
    endcase
  end

endmodule

// File: rtl/tpf_chk.sv
module tpf_chk #(
  parameter int NPIN = 4,
  parameter int PW   = 9,
  parameter int AW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            freeze,
  input logic            step_pend,
  input logic            step_set,
  input logic [NPIN-1:0] pins_q,
  input logic [PW-1:0]   presc,
  input logic [AW-1:0]   acc,
  input logic            ovf,
  input logic            acc_inc
);

  // R1: frozen without a step leaves the prescaler alone
  a_r1_presc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !step_pend) |=> $stable(presc));

  // R1: running prescaler moves by one each clock
  a_r1_presc_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze) |=> (presc == PW'($past(presc) + 1'b1)));

  // R2: frozen without a step leaves pins and accumulator alone
  a_r2_pins_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !step_pend) |=> ($stable(pins_q) && $stable(acc)));

  // R4: a pending step while frozen gives exactly one increment
  a_r4_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && step_pend) |=> (presc == PW'($past(presc) + 1'b1)));

  // R5: the step bit drops after its tick unless re-armed
  a_r5_step_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (step_pend && !step_set) |=> !step_pend);

  // R7: no step can be pending while running
  a_r7_no_step_running: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze) |=> !step_pend);

  // R6: wrap of the accumulator raises the overflow flag
  a_r6_wrap_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_inc && (acc == {AW{1'b1}})) |=> (acc == '0 && ovf));

  // R6: the accumulator only moves on a counted edge
  a_r6_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_inc) |=> $stable(acc));

endmodule

bind tpf_top tpf_chk #(.NPIN(NPIN), .PW(PW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .freeze    (freeze),
  .step_pend (step_pend),
  .step_set  (step_set),
  .pins_q    (pins_q),
  .presc     (presc),
  .acc       (acc),
  .ovf       (ovf),
  .acc_inc   (acc_inc)
);

// File: tb/tpf_top_tb.sv
`timescale 1ns/100ps
module tpf_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  pin_in = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [3:0]  wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tpf_top u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // ---------------- behavioural reference model ----------------
  int         m_presc, m_acc;
  bit         m_ovf, m_stop, m_pend;
  int         m_sel;
  logic [3:0] hist[$];   // [0] oldest sampled vector, [2] newest

  task automatic model_reset();
    m_presc = 0; m_acc = 0; m_ovf = 0; m_stop = 0; m_pend = 0; m_sel = 0;
    hist = '{4'h0, 4'h0, 4'h0};
  endtask

  initial model_reset();

  always @(posedge clk) begin
    bit adv, hit, rs;
    if (!rst_n) model_reset();
    else begin
      adv = !m_stop || m_pend;
      hit = 0;
      if (adv) begin
        rs = hist[1][m_sel] && !hist[0][m_sel];
        m_presc = (m_presc + 1) % 512;
        if (rs) begin
          if (m_acc == 255) begin m_acc = 0; m_ovf = 1; hit = 1; end
          else m_acc = m_acc + 1;
        end
        hist.push_back(pin_in);
        void'(hist.pop_front());
      end
      if (wr_en && wr_addr == 2'd3 && !hit) m_ovf = 0;
      if (wr_en && wr_addr == 2'd0) begin
        if (wr_data[1] && m_stop) m_pend = 1;
        else if (adv) m_pend = 0;
        m_stop = wr_data[0];
        m_sel  = int'(wr_data[3:2]);
      end else if (adv) m_pend = 0;
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // compare every address against the model on each falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      rd_addr = 2'd0; #0.1; check("R5 model ctrl", int'(rd_data), (m_sel << 2) | (int'(m_pend) << 1) | int'(m_stop));
      rd_addr = 2'd1; #0.1; check("R3 model pins", int'(rd_data), int'(hist[1]));
      rd_addr = 2'd2; #0.1; check("R1 model presc", int'(rd_data), m_presc);
      rd_addr = 2'd3; #0.1; check("R6 model acc", int'(rd_data), (int'(m_ovf) << 8) | m_acc);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a; #0.1; v = int'(rd_data);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #0.5;
  endtask

  task automatic pulse(input int idx);
    @(posedge clk); #1; pin_in[idx] = 1'b1;
    repeat (3) @(posedge clk); #1; pin_in[idx] = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  // watchdog
  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int v, p0, a0, base;
    // R9 reset state
    #12;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); check("R9 reset value", v, 0);
    end
    @(posedge clk); #1; rst_n = 1'b1;

    // R1 running count
    wait_clk(3);
    rd(2'd2, p0); wait_clk(1); rd(2'd2, v);
    check("R1 increment", v, (p0 + 1) % 512);
    wait_clk(520); // crosses the 511 -> 0 wrap, model-compared

    // R3 synchronizer latency
    @(posedge clk); #1; pin_in = 4'b0101;
    wait_clk(1); rd(2'd1, v); check("R3 not yet through", v, 0);
    wait_clk(1); rd(2'd1, v); check("R3 two stages", v, 5);

    // R2 freeze with sel = 2
    wr(2'd0, 4'b1001);
    wait_clk(1);
    rd(2'd2, p0); rd(2'd3, a0);
    pin_in = 4'b1010;
    wait_clk(8);
    rd(2'd1, v); check("R2 pins held", v, 5);
    rd(2'd2, v); check("R1 presc frozen", v, p0);
    rd(2'd3, v); check("R2 acc frozen", v, a0);

    // R4 single step: pin2 rising 0->... pin2 already 1 in 0101; use step shifting
    wr(2'd0, 4'b1011);
    wait_clk(2);
    rd(2'd2, v); check("R4 one increment", v, (p0 + 1) % 512);
    rd(2'd0, v); check("R5 step self-clear", v & 2, 0);
    rd(2'd1, v); check("R4 second stage unchanged", v, 5);
    wr(2'd0, 4'b1011);
    wait_clk(2);
    rd(2'd1, v); check("R4 second step shifts", v, 10);
    rd(2'd2, v); check("R5 repeated step", v, (p0 + 2) % 512);

    // R4 edge travel: clear pin2, settle, then rise under stepping
    pin_in = 4'b0000;
    for (int k = 0; k < 3; k++) begin wr(2'd0, 4'b1011); wait_clk(1); end
    rd(2'd3, a0);
    pin_in = 4'b0100;
    wr(2'd0, 4'b1011); wait_clk(1);
    wr(2'd0, 4'b1011); wait_clk(1);
    rd(2'd1, v); check("R4 edge at stage two", v & 4, 4);
    rd(2'd3, v); check("R4 not counted yet", v, a0);
    wr(2'd0, 4'b1011); wait_clk(1);
    rd(2'd3, v); check("R4 counted on third step", v & 255, (a0 + 1) % 256);

    // R8 resume without loss
    rd(2'd2, p0);
    wr(2'd0, 4'b1000);
    rd(2'd2, v); check("R8 first clock after write holds", v, p0);
    wait_clk(1); rd(2'd2, v); check("R8 resume by one", v, (p0 + 1) % 512);

    // R7 step while running has no effect
    wr(2'd0, 4'b1010);
    #0.5; rd(2'd0, v); check("R7 step ignored", v, 4'b1000);
    wait_clk(1); rd(2'd0, v); check("R7 still clear", v, 4'b1000);

    // R6 edge counting with wrap; unselected pin pulses ignored
    pin_in = 4'b0000; wait_clk(4);
    wr(2'd3, 4'b0000);
    wait_clk(1);
    rd(2'd3, base); base = base & 255;
    for (int k = 0; k < 4; k++) pulse(0);
    wait_clk(3); rd(2'd3, v); check("R6 other pin ignored", v, base);
    for (int k = 0; k < 260; k++) pulse(2);
    wait_clk(3);
    rd(2'd3, v);
    check("R6 wrapped count", v & 255, (base + 260) % 256);
    check("R6 overflow flag", (v >> 8) & 1, 1);
    wr(2'd3, 4'b0000);
    wait_clk(1); rd(2'd3, v); check("R6 overflow cleared", (v >> 8) & 1, 0);

    wait_clk(4);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule